// File: doc/BRIEF.md
# Radix-8 Booth Signed Multiplier

This block multiplies two signed two's-complement operands with purely combinational logic and returns the full double-width product. The multiplier operand is cut into overlapping four-bit windows. Each window becomes one signed digit between -4 and +4, so a 16-bit multiplier needs only six partial products. A plain bit-by-bit scheme would need sixteen.

Each digit selects one multiple of the multiplicand: zero, X, 2X, 3X or 4X. The digit's sign can invert that multiple. The block then shifts the multiple into place at three bits per digit. The hard multiple 3X is formed once, up front, by a prefix adder that sums X and 2X.

A chain of carry-save stages folds all rows into a sum vector and a carry vector. A Kogge-Stone prefix adder then resolves them into the product. The block has no clock and no state. A caller samples the product in whatever register follows it.

Top module: `booth8_mul`

## Requirements
- R1: `prod_o` equals the exact signed product of `mcand_i` and `mplr_i`, both read as two's complement, as a 32-bit two's-complement value.
- R2: `prod_o[31]` is 1 exactly when both operands are nonzero and exactly one of them is negative.
- R3: The multiplier, sign-extended to 18 bits with a 0 appended below bit 0, is read in six windows of 4 bits, window i covering extended bits 3i+3 down to 3i. Bit 3 is the top bit and carries weight -4; bits 2, 1 and 0 carry weights +2, +1 and +1. For example, 0111 gives +4, 1000 gives -4, and 1111 and 0000 give 0. Window i is weighted by 8^i. No digit has a magnitude above 4.
- R4: The 3X multiple is 3 times the multiplicand, held in 18 signed bits, and is correct for the extreme values -32768 and 32767.
- R5: A negative digit forms its row as the inverted multiple plus a 1 at bit 3i. Only digits with a nonzero magnitude are negative. The product is exact when the multiplicand is -32768 under any digit, including -4.
- R6: When either operand is 0, `prod_o` is 0.
- R7: The final adder returns the sum of its two 32-bit inputs modulo 2^32, with the carry out of bit 31 dropped. This holds even for carries that travel across the full width.
- R8: When the multiplier is -1 (all ones), `prod_o` is the negated, sign-extended multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | 16 | Multiplicand, two's complement |
| mplr_i | input | 16 | Multiplier, two's complement, the operand that is Booth recoded |
| prod_o | output | 32 | Signed product, two's complement |

## Verification
The checks assume that both operands hold known 0/1 values, and they skip any evaluation where either operand has unknown bits. The stimulus drives both operands in every test, starting at time zero, and changes them only well away from the bench clock edge. The product therefore always settles from fully known inputs before it is sampled. The directed tests aim at digit patterns one window at a time, the two extreme operand values, and carry chains that run the full width. A pseudo-random sweep then covers everything else.

// File: rtl/booth8_pkg.sv
package booth8_pkg;

    // One recoded digit: sign flag plus magnitude 0..4
    typedef struct packed {
        logic       neg;
        logic [2:0] mag;
    } digit_t;

    // Window weights: -4 for bit 3, +2 / +1 / +1 for bits 2..0
    function automatic digit_t decode_win(input logic [3:0] w);
        digit_t     d;
        logic [2:0] s;
        s = 3'(w[2]) + 3'(w[2]) + 3'(w[1]) + 3'(w[0]);
        if (w[3]) begin
            d.neg = (s != 3'd4);
            d.mag = 3'd4 - s;
        end else begin
            d.neg = 1'b0;
            d.mag = s;
        end
        return d;
    endfunction

endpackage

// File: rtl/ks_prefix_adder.sv
module ks_prefix_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] sum_o
);
    localparam int LVL = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0] g_q [0:LVL];
    logic [W-1:0] p_q [0:LVL];
    logic [W-1:0] carry_d;

    // pre-computation
    assign p_q[0] = x_i ^ y_i;
    assign g_q[0] = x_i & y_i;

    // prefix network, span doubles each level
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        localparam int SPAN = 1 << l;
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= SPAN) begin : g_cell
                assign g_q[l+1][i] = g_q[l][i] | (p_q[l][i] & g_q[l][i-SPAN]);
                assign p_q[l+1][i] = p_q[l][i] & p_q[l][i-SPAN];
            end else begin : g_pass
                assign g_q[l+1][i] = g_q[l][i];
                assign p_q[l+1][i] = p_q[l][i];
            end
        end
    end

    // sum formation: carry into bit i is group generate of bits i-1..0
    always_comb begin
        carry_d = {g_q[LVL][W-2:0], 1'b0};
        sum_o   = p_q[0] ^ carry_d;
    end
endmodule

// File: rtl/booth8_recoder.sv
module booth8_recoder
    import booth8_pkg::*;
#(
    parameter int B_W = 16,
    parameter int NPP = (B_W + 2) / 3
) (
    input  logic [B_W-1:0]           mplr_i,
    output digit_t [NPP-1:0]         dig_o
);
    localparam int EXT_W = 3 * NPP + 1;

    logic [EXT_W-1:0] ext_d;

    assign ext_d = {{(EXT_W - B_W - 1){mplr_i[B_W-1]}}, mplr_i, 1'b0};

    for (genvar i = 0; i < NPP; i++) begin : g_win
        assign dig_o[i] = decode_win(ext_d[3*i+3 -: 4]);
    end
endmodule

// File: rtl/booth8_pp_row.sv
module booth8_pp_row
    import booth8_pkg::*;
#(
    parameter int A_W   = 16,
    parameter int P_W   = 32,
    parameter int SHIFT = 0
) (
    input  logic [A_W-1:0] x1_i,
    input  logic [A_W+1:0] x3_i,
    input  digit_t         dig_i,
    output logic [P_W-1:0] row_o
);
    localparam int M_W = A_W + 3;

    logic [M_W-1:0] x1s_d;
    logic [M_W-1:0] mult_d;
    logic [P_W-1:0] wide_d;

    assign x1s_d = {{3{x1_i[A_W-1]}}, x1_i};

    always_comb begin
        unique case (dig_i.mag)
            3'd1:    mult_d = x1s_d;
            3'd2:    mult_d = x1s_d << 1;
            3'd3:    mult_d = {x3_i[A_W+1], x3_i};
            3'd4:    mult_d = x1s_d << 2;
            default: mult_d = '0;
        endcase
        if (dig_i.neg) begin
            mult_d = ~mult_d;
        end
        wide_d = {{(P_W - M_W){mult_d[M_W-1]}}, mult_d};
        row_o  = wide_d << SHIFT;
    end
endmodule

// File: rtl/booth8_csa_chain.sv
module booth8_csa_chain #(
    parameter int W = 32,
    parameter int N = 7
) (
    input  logic [N-1:0][W-1:0] rows_i,
    output logic [W-1:0]        sum_o,
    output logic [W-1:0]        carry_o
);
    logic [W-1:0] s_q [1:N-1];
    logic [W-1:0] c_q [1:N-1];

    assign s_q[1] = rows_i[0];
    assign c_q[1] = rows_i[1];

    // 3:2 compression, one new row per stage
    for (genvar k = 2; k < N; k++) begin : g_stage
        logic [W-1:0] maj_d;
        assign s_q[k] = s_q[k-1] ^ c_q[k-1] ^ rows_i[k];
        assign maj_d  = (s_q[k-1] & c_q[k-1]) | (s_q[k-1] & rows_i[k])
                      | (c_q[k-1] & rows_i[k]);
        assign c_q[k] = maj_d << 1;
    end

    assign sum_o   = s_q[N-1];
    assign carry_o = c_q[N-1];
endmodule

// File: rtl/booth8_mul.sv
module booth8_mul
    import booth8_pkg::*;
#(
    parameter int A_W = 16,
    parameter int B_W = 16
) (
    input  logic [A_W-1:0]     mcand_i,
    input  logic [B_W-1:0]     mplr_i,
    output logic [A_W+B_W-1:0] prod_o
);
    localparam int P_W  = A_W + B_W;
    localparam int NPP  = (B_W + 2) / 3;
    localparam int NROW = NPP + 1;
    localparam int T_W  = A_W + 2;

    digit_t [NPP-1:0]        dig_d;
    logic [T_W-1:0]          x1t_d;
    logic [T_W-1:0]          x2t_d;
    logic [T_W-1:0]          triple_d;
    logic [NROW-1:0][P_W-1:0] rows_d;
    logic [P_W-1:0]          corr_d;
    logic [P_W-1:0]          ks_x_d;
    logic [P_W-1:0]          ks_y_d;

    // 3X = X + 2X, formed once
    assign x1t_d = {{2{mcand_i[A_W-1]}}, mcand_i};
    assign x2t_d = x1t_d << 1;

    ks_prefix_adder #(.W(T_W)) u_triple (
        .x_i   (x1t_d),
        .y_i   (x2t_d),
        .sum_o (triple_d)
    );

    booth8_recoder #(.B_W(B_W), .NPP(NPP)) u_rec (
        .mplr_i (mplr_i),
        .dig_o  (dig_d)
    );

    for (genvar i = 0; i < NPP; i++) begin : g_row
        booth8_pp_row #(.A_W(A_W), .P_W(P_W), .SHIFT(3 * i)) u_row (
            .x1_i  (mcand_i),
            .x3_i  (triple_d),
            .dig_i (dig_d[i]),
            .row_o (rows_d[i])
        );
    end

    // +1 injections completing the negation of each negative row
    always_comb begin
        corr_d = '0;
        for (int i = 0; i < NPP; i++) begin
            corr_d[3*i] = dig_d[i].neg;
        end
    end
    assign rows_d[NPP] = corr_d;

    booth8_csa_chain #(.W(P_W), .N(NROW)) u_csa (
        .rows_i  (rows_d),
        .sum_o   (ks_x_d),
        .carry_o (ks_y_d)
    );

    ks_prefix_adder #(.W(P_W)) u_final (
        .x_i   (ks_x_d),
        .y_i   (ks_y_d),
        .sum_o (prod_o)
    );
endmodule

// File: rtl/booth8_mul_chk.sv
module booth8_mul_chk
    import booth8_pkg::*;
#(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int NPP = (B_W + 2) / 3
) (
    input  logic [A_W-1:0]     mcand_i,
    input  logic [B_W-1:0]     mplr_i,
    input  logic [A_W+B_W-1:0] prod_o,
    input  logic [A_W+1:0]     triple_i,
    input  digit_t [NPP-1:0]   dig_i,
    input  logic [A_W+B_W-1:0] ks_x_i,
    input  logic [A_W+B_W-1:0] ks_y_i
);
    localparam int P_W = A_W + B_W;
    localparam int T_W = A_W + 2;

    logic signed [P_W-1:0] ea_d;
    logic signed [P_W-1:0] eb_d;
    logic signed [T_W-1:0] ta_d;
    logic                  known_d;

    assign ea_d    = P_W'($signed(mcand_i));
    assign eb_d    = P_W'($signed(mplr_i));
    assign ta_d    = T_W'($signed(mcand_i));
    assign known_d = !$isunknown({mcand_i, mplr_i});

    always_comb begin
        if (known_d) begin
            AST_PRODUCT_EXACT: assert (prod_o == P_W'(ea_d * eb_d)); // R1
            AST_PRODUCT_SIGN: assert (prod_o[P_W-1] ==
                ((mcand_i != '0) && (mplr_i != '0) && (mcand_i[A_W-1] ^ mplr_i[B_W-1]))); // R2
            AST_TRIPLE_VALUE: assert (triple_i == T_W'(ta_d + ta_d + ta_d)); // R4
            AST_ZERO_OPERAND: assert (!((mcand_i == '0) || (mplr_i == '0)) || (prod_o == '0)); // R6
            AST_FINAL_SUM: assert (prod_o == P_W'(ks_x_i + ks_y_i)); // R7
            AST_MINUS_ONE: assert (!(&mplr_i) || (prod_o == P_W'(-ea_d))); // R8
            for (int i = 0; i < NPP; i++) begin
                AST_DIGIT_RANGE: assert (dig_i[i].mag <= 3'd4); // R3
                AST_NEG_NONZERO: assert (!dig_i[i].neg || (dig_i[i].mag != 3'd0)); // R5
            end
        end
    end
endmodule

bind booth8_mul booth8_mul_chk #(.A_W(A_W), .B_W(B_W), .NPP(NPP)) u_chk (
    .mcand_i  (mcand_i),
    .mplr_i   (mplr_i),
    .prod_o   (prod_o),
    .triple_i (triple_d),
    .dig_i    (dig_d),
    .ks_x_i   (ks_x_d),
    .ks_y_i   (ks_y_d)
);

// File: tb/sim_booth8_mul.sv
module sim_booth8_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a   = '0;
    logic [15:0] b   = '0;
    logic [31:0] p;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    booth8_mul u0 (
        .mcand_i (a),
        .mplr_i  (b),
        .prod_o  (p)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] ex;
        logic signed [31:0] ey;
        ex = 32'($signed(x));
        ey = 32'($signed(y));
        return 32'(ex * ey);
    endfunction

    task automatic apply_check(input logic [15:0] x, input logic [15:0] y, input string req);
        logic [31:0] exp_v;
        @(posedge clk);
        #1;
        a = x;
        b = y;
        #3;
        exp_v = ref_mul(x, y);
        total++;
        if (p !== exp_v) begin
            bad++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, p, exp_v);
        end
    endtask

    task automatic t_reset_state;
        // operands held at zero through reset: product must be zero (R6)
        #4;
        total++;
        if (p !== 32'h0) begin
            bad++;
            $display("FAIL R6 reset actual=%h expected=%h", p, 32'h0);
        end
    endtask

    task automatic t_zero;
        apply_check(16'h0000, 16'h7fff, "R6");
        apply_check(16'h8000, 16'h0000, "R6");
        apply_check(16'h1234, 16'h0000, "R6");
    endtask

    task automatic t_minus_one;
        apply_check(16'h7fff, 16'hffff, "R8");
        apply_check(16'h8000, 16'hffff, "R8");
        apply_check(16'h0001, 16'hffff, "R8");
        apply_check(16'hffff, 16'hffff, "R8");
    endtask

    task automatic t_extremes;
        apply_check(16'h8000, 16'h8000, "R5");
        apply_check(16'h8000, 16'h7fff, "R5");
        apply_check(16'h7fff, 16'h8000, "R5");
        apply_check(16'h7fff, 16'h7fff, "R1");
    endtask

    task automatic t_windows;
        // each 3-bit group alone, with every value, so each window sees all codes (R3)
        for (int g = 0; g < 6; g++) begin
            for (int v = 1; v < 8; v++) begin
                apply_check(16'h8000, 16'(v << (3 * g)), "R3");
                apply_check(16'h5a5b, 16'(~(v << (3 * g))), "R3");
            end
        end
    endtask

    task automatic t_triple;
        // digit +3 and -3 select the triple multiple (R4)
        apply_check(16'h7fff, 16'h0003, "R4");
        apply_check(16'h8000, 16'h0003, "R4");
        apply_check(16'h8000, 16'hfffd, "R4");
        apply_check(16'h7fff, 16'h0018, "R4");
        apply_check(16'h8001, 16'h6db6, "R4");
    endtask

    task automatic t_sign;
        logic [15:0] xs [4];
        xs = '{16'h0005, 16'hfffb, 16'h8000, 16'h7fff};
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic exp_s;
                @(posedge clk);
                #1;
                a = xs[i];
                b = xs[j];
                #3;
                exp_s = xs[i][15] ^ xs[j][15];
                total++;
                if (p[31] !== exp_s) begin
                    bad++;
                    $display("FAIL R2 a=%h b=%h actual=%b expected=%b", a, b, p[31], exp_s);
                end
            end
        end
    endtask

    task automatic t_carry_chain;
        // products whose sum vectors force carries across all 32 bits (R7)
        apply_check(16'hffff, 16'h0001, "R7");
        apply_check(16'h8000, 16'h0001, "R7");
        apply_check(16'h0001, 16'h8000, "R7");
        apply_check(16'hffff, 16'h8000, "R7");
    endtask

    task automatic t_random;
        logic [31:0] lfsr = 32'hace1_2468;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply_check(lfsr[15:0], lfsr[31:16], "R1");
        end
    endtask

    initial begin
        t_reset_state();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        t_zero();
        t_minus_one();
        t_extremes();
        t_windows();
        t_triple();
        t_sign();
        t_carry_chain();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule